// File: doc/BRIEF.md
# Software-Filled Associative Translation Buffer

This block is a small fully associative address translation cache whose contents software loads one slot at a time. Each slot holds a virtual page number, a per-slot don't-care mask over that page number, an address-space tag, a global flag, two independent valid flags and a physical frame number. Two search ports look at every slot in parallel. The lookup port returns hit and frame number. The probe port returns the slot index, or an all-ones code on a miss.

Software writes a whole slot at an explicit index. A flush command wipes the table. A round-robin victim pointer lets software read the slot it points at and, if it chooses, step the pointer to the next slot. The lookup port also flags a request as uncacheable when its virtual address lies in a fixed region. Both search ports answer combinationally from the current table and also give registered copies one cycle later. Writes, flushes and pointer steps take effect from the following cycle.

Top module: `swtlb`

## Requirements
- R1: A live slot matches a search key when the key's page number and the stored page number are equal on every bit where the slot's mask bit is 0. Mask bits set to 1 are don't-care.
- R2: A slot whose global flag is 1 matches any address-space tag. A slot whose global flag is 0 matches only when the search tag equals its stored tag.
- R3: A slot is live when either of its two valid flags is 1. A slot with both flags 0 never matches.
- R4: When several slots match, the lowest index is reported, and its frame number is returned.
- R5: `pr_idx` is {1'b0, index} on a hit and all ones (5'h1F at the default 16 slots) on a miss. `lk_pfn` is 0 on a miss.
- R6: A write with `wr_idx` below the slot count replaces every field of that slot. A search in the same cycle still sees the old contents, and the new contents are seen from the next cycle.
- R7: A write with `wr_idx` at or above the slot count changes no slot, and `wr_warn` is 1 for exactly the following cycle.
- R8: `flush` clears every slot, including both valid flags, and returns the victim pointer to 0. If a write arrives in the same cycle, the flush takes priority.
- R9: The `rp_*` outputs show the slot at the victim pointer. `rp_adv` steps the pointer by one, wrapping from the last slot to 0. Without `rp_adv` or `flush` the pointer holds.
- R10: `lk_uc` is 1 exactly when (`lk_va` AND 0xA0000000) equals 0xA0000000.
- R11: `lk_hit_q`, `lk_pfn_q`, `lk_uc_q` and `pr_idx_q` equal the combinational results of the previous cycle.
- R12: After a synchronous reset every slot is dead, the pointer is 0, `wr_warn` is 0 and `pr_idx_q` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_va | input | VA_W | Lookup virtual address for the cacheability check |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pfn | output | PFN_W | Frame number of the winning slot, 0 on a miss |
| lk_uc | output | 1 | Address is in the uncacheable region |
| lk_hit_q | output | 1 | Registered lookup hit |
| lk_pfn_q | output | PFN_W | Registered frame number |
| lk_uc_q | output | 1 | Registered uncacheable flag |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe address-space tag |
| pr_idx | output | IDX_W+1 | Probe result index, all ones on a miss |
| pr_idx_q | output | IDX_W+1 | Registered probe result |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Target slot of the write |
| wr_vpn | input | VPN_W | New page number |
| wr_mask | input | VPN_W | New don't-care mask |
| wr_asid | input | ASID_W | New address-space tag |
| wr_glob | input | 1 | New global flag |
| wr_v0 | input | 1 | New first valid flag |
| wr_v1 | input | 1 | New second valid flag |
| wr_pfn | input | PFN_W | New frame number |
| wr_warn | output | 1 | Previous cycle held an out-of-range write |
| flush | input | 1 | Clear the whole table and the pointer |
| rp_adv | input | 1 | Step the victim pointer |
| rp_ptr | output | IDX_W | Victim pointer |
| rp_vpn | output | VPN_W | Page number of the slot at the pointer |
| rp_mask | output | VPN_W | Mask of the slot at the pointer |
| rp_asid | output | ASID_W | Tag of the slot at the pointer |
| rp_glob | output | 1 | Global flag of the slot at the pointer |
| rp_v0 | output | 1 | First valid flag of the slot at the pointer |
| rp_v1 | output | 1 | Second valid flag of the slot at the pointer |
| rp_pfn | output | PFN_W | Frame number of the slot at the pointer |

## Verification
The bench loads the same page number into two slots to test lowest-index priority. A design that scanned from the top, or ORed the frame numbers together, would return the wrong frame. It loads a slot with only the second valid flag set and a slot with neither set, which catches a liveness test that looks at one flag only. It also searches under masked page numbers, foreign tags and global slots, so an inverted mask or a missing global bypass shows up as a spurious hit or miss. Writes at index 16 and 31 check that a bounds test using greater-than rather than greater-or-equal would corrupt a slot or miss the warning. The remaining cases are a flush issued together with a write, pointer wrap at slot 15, and a search in the same cycle as a write to the slot being searched; any of these handled in the wrong order would show a stale or early value.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int unsigned SLOTS_DEF  = 16;
  localparam int unsigned VPN_W_DEF  = 20;
  localparam int unsigned PFN_W_DEF  = 20;
  localparam int unsigned ASID_W_DEF = 8;
  localparam int unsigned VA_W_DEF   = 32;
  localparam logic [31:0] UC_REGION_DEF = 32'hA000_0000;

  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_STEP  = 2'd1,
    PTR_CLEAR = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned PIDX_W = $clog2(SLOTS) + 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               flush,
  input  logic                               wr_en,
  input  logic [PIDX_W-1:0]                  wr_idx,
  input  logic [VPN_W-1:0]                   wr_vpn,
  input  logic [VPN_W-1:0]                   wr_mask,
  input  logic [ASID_W-1:0]                  wr_asid,
  input  logic                               wr_glob,
  input  logic                               wr_v0,
  input  logic                               wr_v1,
  input  logic [PFN_W-1:0]                   wr_pfn,
  output logic [SLOTS-1:0][VPN_W-1:0]        e_vpn,
  output logic [SLOTS-1:0][VPN_W-1:0]        e_mask,
  output logic [SLOTS-1:0][ASID_W-1:0]       e_asid,
  output logic [SLOTS-1:0]                   e_glob,
  output logic [SLOTS-1:0]                   e_v0,
  output logic [SLOTS-1:0]                   e_v1,
  output logic [SLOTS-1:0][PFN_W-1:0]        e_pfn,
  output logic                               wr_warn
);
  localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(SLOTS);

  logic oob;
  assign oob = wr_idx >= LIMIT;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == PIDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        e_vpn[i]  <= '0;
        e_mask[i] <= '0;
        e_asid[i] <= '0;
        e_glob[i] <= 1'b0;
        e_v0[i]   <= 1'b0;
        e_v1[i]   <= 1'b0;
        e_pfn[i]  <= '0;
      end else if (sel) begin
        e_vpn[i]  <= wr_vpn;
        e_mask[i] <= wr_mask;
        e_asid[i] <= wr_asid;
        e_glob[i] <= wr_glob;
        e_v0[i]   <= wr_v0;
        e_v1[i]   <= wr_v1;
        e_pfn[i]  <= wr_pfn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_warn <= 1'b0;
    else     wr_warn <= wr_en && oob;
  end
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic [VPN_W-1:0]                   key_vpn,
  input  logic [ASID_W-1:0]                  key_asid,
  input  logic [SLOTS-1:0][VPN_W-1:0]        e_vpn,
  input  logic [SLOTS-1:0][VPN_W-1:0]        e_mask,
  input  logic [SLOTS-1:0][ASID_W-1:0]       e_asid,
  input  logic [SLOTS-1:0]                   e_glob,
  input  logic [SLOTS-1:0]                   e_v0,
  input  logic [SLOTS-1:0]                   e_v1,
  output logic                               hit,
  output logic [IDX_W-1:0]                   idx
);
  logic [SLOTS-1:0] m;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    logic live, vpn_ok, asid_ok;
    assign live    = e_v0[i] | e_v1[i];
    assign vpn_ok  = ~|((key_vpn ^ e_vpn[i]) & ~e_mask[i]);
    assign asid_ok = e_glob[i] | (e_asid[i] == key_asid);
    assign m[i]    = live & vpn_ok & asid_ok;
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/swtlb_rrptr.sv
module swtlb_rrptr #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  import swtlb_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  ptr_op_e op;

  always_comb begin
    if (flush)    op = PTR_CLEAR;
    else if (adv) op = PTR_STEP;
    else          op = PTR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      unique case (op)
        PTR_CLEAR: ptr <= '0;
        PTR_STEP:  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        default:   ptr <= ptr;
      endcase
    end
  end
endmodule

// File: rtl/swtlb.sv
module swtlb #(
  parameter int unsigned SLOTS  = swtlb_pkg::SLOTS_DEF,
  parameter int unsigned VPN_W  = swtlb_pkg::VPN_W_DEF,
  parameter int unsigned PFN_W  = swtlb_pkg::PFN_W_DEF,
  parameter int unsigned ASID_W = swtlb_pkg::ASID_W_DEF,
  parameter int unsigned VA_W   = swtlb_pkg::VA_W_DEF,
  parameter logic [VA_W-1:0] UC_REGION = VA_W'(swtlb_pkg::UC_REGION_DEF),
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned PIDX_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_uc,
  output logic              lk_hit_q,
  output logic [PFN_W-1:0]  lk_pfn_q,
  output logic              lk_uc_q,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [PIDX_W-1:0] pr_idx,
  output logic [PIDX_W-1:0] pr_idx_q,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic              wr_warn,
  input  logic              flush,
  input  logic              rp_adv,
  output logic [IDX_W-1:0]  rp_ptr,
  output logic [VPN_W-1:0]  rp_vpn,
  output logic [VPN_W-1:0]  rp_mask,
  output logic [ASID_W-1:0] rp_asid,
  output logic              rp_glob,
  output logic              rp_v0,
  output logic              rp_v1,
  output logic [PFN_W-1:0]  rp_pfn
);
  logic [SLOTS-1:0][VPN_W-1:0]  e_vpn, e_mask;
  logic [SLOTS-1:0][ASID_W-1:0] e_asid;
  logic [SLOTS-1:0]             e_glob, e_v0, e_v1;
  logic [SLOTS-1:0][PFN_W-1:0]  e_pfn;

  logic             lk_m, pr_m;
  logic [IDX_W-1:0] lk_i, pr_i;

  swtlb_store #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_pfn(wr_pfn),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_v0(e_v0), .e_v1(e_v1), .e_pfn(e_pfn), .wr_warn(wr_warn)
  );

  swtlb_match #(.SLOTS(SLOTS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk (
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_v0(e_v0), .e_v1(e_v1), .hit(lk_m), .idx(lk_i)
  );

  swtlb_match #(.SLOTS(SLOTS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr (
    .key_vpn(pr_vpn), .key_asid(pr_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_v0(e_v0), .e_v1(e_v1), .hit(pr_m), .idx(pr_i)
  );

  swtlb_rrptr #(.SLOTS(SLOTS)) u_ptr (
    .clk(clk), .rst(rst), .flush(flush), .adv(rp_adv), .ptr(rp_ptr)
  );

  assign lk_hit = lk_m;
  assign lk_pfn = lk_m ? e_pfn[lk_i] : '0;
  assign lk_uc  = (lk_va & UC_REGION) == UC_REGION;
  assign pr_idx = pr_m ? {1'b0, pr_i} : '1;

  assign rp_vpn  = e_vpn[rp_ptr];
  assign rp_mask = e_mask[rp_ptr];
  assign rp_asid = e_asid[rp_ptr];
  assign rp_glob = e_glob[rp_ptr];
  assign rp_v0   = e_v0[rp_ptr];
  assign rp_v1   = e_v1[rp_ptr];
  assign rp_pfn  = e_pfn[rp_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_q <= 1'b0;
      lk_pfn_q <= '0;
      lk_uc_q  <= 1'b0;
      pr_idx_q <= '1;
    end else begin
      lk_hit_q <= lk_hit;
      lk_pfn_q <= lk_pfn;
      lk_uc_q  <= lk_uc;
      pr_idx_q <= pr_idx;
    end
  end
endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned PIDX_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              wr_en,
  input logic [PIDX_W-1:0] wr_idx,
  input logic              wr_warn,
  input logic              rp_adv,
  input logic [IDX_W-1:0]  rp_ptr,
  input logic              lk_hit,
  input logic              pr_m_code,
  input logic [PIDX_W-1:0] pr_idx
);
  localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(SLOTS);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(SLOTS - 1);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rp_ptr == '0) && !lk_hit && (pr_idx == '1));

  // R7
  oob_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= LIMIT) |=> wr_warn);

  // R7
  no_spurious_warn_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx >= LIMIT) |=> !wr_warn);

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_adv && !flush && rp_ptr == LAST) |=> rp_ptr == '0);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_adv && !flush && rp_ptr != LAST) |=> rp_ptr == $past(rp_ptr) + 1'b1);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rp_adv && !flush) |=> $stable(rp_ptr));

  // R5
  probe_code_chk: assert property (@(posedge clk) disable iff (rst)
    pr_m_code |-> (pr_idx < LIMIT));
endmodule

bind swtlb swtlb_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_warn(wr_warn), .rp_adv(rp_adv), .rp_ptr(rp_ptr), .lk_hit(lk_hit),
  .pr_m_code(pr_m), .pr_idx(pr_idx)
);

// File: tb/tb_swtlb.sv
`timescale 1ns/1ps
module tb_swtlb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [19:0] lk_vpn = '0, pr_vpn = '0, wr_vpn = '0, wr_mask = '0;
  logic [7:0]  lk_asid = '0, pr_asid = '0, wr_asid = '0;
  logic [31:0] lk_va = '0;
  logic [19:0] wr_pfn = '0;
  logic [4:0]  wr_idx = '0;
  logic wr_en = 0, wr_glob = 0, wr_v0 = 0, wr_v1 = 0, flush = 0, rp_adv = 0;

  logic lk_hit, lk_uc, lk_hit_q, lk_uc_q, wr_warn, rp_glob, rp_v0, rp_v1;
  logic [19:0] lk_pfn, lk_pfn_q, rp_vpn, rp_mask, rp_pfn;
  logic [4:0]  pr_idx, pr_idx_q;
  logic [3:0]  rp_ptr;
  logic [7:0]  rp_asid;

  swtlb dut (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_uc(lk_uc), .lk_hit_q(lk_hit_q),
    .lk_pfn_q(lk_pfn_q), .lk_uc_q(lk_uc_q), .pr_vpn(pr_vpn), .pr_asid(pr_asid),
    .pr_idx(pr_idx), .pr_idx_q(pr_idx_q), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_glob(wr_glob),
    .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_pfn(wr_pfn), .wr_warn(wr_warn),
    .flush(flush), .rp_adv(rp_adv), .rp_ptr(rp_ptr), .rp_vpn(rp_vpn),
    .rp_mask(rp_mask), .rp_asid(rp_asid), .rp_glob(rp_glob), .rp_v0(rp_v0),
    .rp_v1(rp_v1), .rp_pfn(rp_pfn)
  );

  // behavioural model
  logic [19:0] m_vpn[N], m_mask[N], m_pfn[N];
  logic [7:0]  m_asid[N];
  logic        m_g[N], m_v0[N], m_v1[N];
  int          m_ptr;
  int          n_cmp = 0, n_bad = 0;
  string       tag = "R12";
  bit          done = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int mfind(logic [19:0] v, logic [7:0] a);
    for (int i = 0; i < N; i++)
      if ((m_v0[i] || m_v1[i]) && (((v ^ m_vpn[i]) & ~m_mask[i]) == 20'h0) &&
          (m_g[i] || m_asid[i] == a))
        return i;
    return -1;
  endfunction

  task automatic mclear();
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_pfn[i] = '0; m_asid[i] = '0;
      m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0;
    end
    m_ptr = 0;
  endtask

  // one clock: compare combinational outputs, advance, compare registered outputs
  task automatic step();
    int li, pi;
    logic [19:0] e_pfn;
    logic e_hit, e_uc, e_warn;
    logic [4:0] e_pr;
    #1;
    li = mfind(lk_vpn, lk_asid);
    pi = mfind(pr_vpn, pr_asid);
    e_hit = (li >= 0);
    e_pfn = (li >= 0) ? m_pfn[li] : 20'h0;
    e_uc  = (lk_va & 32'hA000_0000) == 32'hA000_0000;
    e_pr  = (pi >= 0) ? 5'(pi) : 5'h1F;
    e_warn = wr_en && (wr_idx >= 5'd16);
    chk("lk_hit", 64'(lk_hit), 64'(e_hit));
    chk("lk_pfn", 64'(lk_pfn), 64'(e_pfn));
    chk("lk_uc", 64'(lk_uc), 64'(e_uc));
    chk("pr_idx", 64'(pr_idx), 64'(e_pr));
    chk("rp_ptr", 64'(rp_ptr), 64'(m_ptr));
    chk("rp_entry", {rp_vpn, rp_mask, rp_asid, rp_glob, rp_v0, rp_v1},
        {m_vpn[m_ptr], m_mask[m_ptr], m_asid[m_ptr], m_g[m_ptr], m_v0[m_ptr], m_v1[m_ptr]});
    chk("rp_pfn", 64'(rp_pfn), 64'(m_pfn[m_ptr]));
    if (flush) mclear();
    else begin
      if (wr_en && wr_idx < 5'd16) begin
        m_vpn[wr_idx] = wr_vpn; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_glob; m_v0[wr_idx] = wr_v0; m_v1[wr_idx] = wr_v1;
        m_pfn[wr_idx] = wr_pfn;
      end
      if (rp_adv) m_ptr = (m_ptr + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
    // R11 registered copies
    chk("lk_hit_q", 64'(lk_hit_q), 64'(e_hit));
    chk("lk_pfn_q", 64'(lk_pfn_q), 64'(e_pfn));
    chk("lk_uc_q", 64'(lk_uc_q), 64'(e_uc));
    chk("pr_idx_q", 64'(pr_idx_q), 64'(e_pr));
    chk("wr_warn", 64'(wr_warn), 64'(e_warn));
    wr_en = 0; flush = 0; rp_adv = 0;
  endtask

  task automatic wr(int idx, logic [19:0] v, logic [19:0] msk, logic [7:0] a,
                    logic g, logic v0, logic v1, logic [19:0] p);
    wr_en = 1; wr_idx = 5'(idx); wr_vpn = v; wr_mask = msk; wr_asid = a;
    wr_glob = g; wr_v0 = v0; wr_v1 = v1; wr_pfn = p;
  endtask

  task automatic look(logic [19:0] v, logic [7:0] a);
    lk_vpn = v; lk_asid = a; pr_vpn = v; pr_asid = a;
  endtask

  initial begin
    mclear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    tag = "R12";
    chk("pr_idx_q", 64'(pr_idx_q), 64'h1F);
    chk("lk_hit_q", 64'(lk_hit_q), 64'h0);
    chk("wr_warn", 64'(wr_warn), 64'h0);
    chk("rp_ptr", 64'(rp_ptr), 64'h0);
    look(20'h12345, 8'd5); step();

    // R6 fill, with same-cycle search still seeing the old slot
    tag = "R6";
    wr(0, 20'h12345, 20'h0, 8'd5, 0, 1, 0, 20'hAAAAA); look(20'h12345, 8'd5); step();
    look(20'h12345, 8'd5); step();
    wr(3, 20'h40000, 20'h000FF, 8'd7, 1, 0, 1, 20'h33333); step();
    wr(5, 20'h12345, 20'h0, 8'd5, 0, 1, 0, 20'h55555); step();
    wr(7, 20'h07777, 20'h0, 8'd1, 1, 0, 0, 20'h77777); step();
    wr(9, 20'h09999, 20'h0, 8'd2, 0, 1, 1, 20'h99999); step();

    // R4 duplicates at 0 and 5: slot 0 wins
    tag = "R4";
    look(20'h12345, 8'd5); step();
    // R1 mask: low 8 bits are don't-care on slot 3
    tag = "R1";
    look(20'h400AB, 8'd0); step();
    look(20'h401AB, 8'd0); step();
    // R2 global vs tagged
    tag = "R2";
    look(20'h400FF, 8'd99); step();
    look(20'h12345, 8'd6); step();
    look(20'h09999, 8'd2); step();
    look(20'h09999, 8'd3); step();
    // R3 dead slot never matches; second flag alone is live
    tag = "R3";
    look(20'h07777, 8'd1); step();
    look(20'h40000, 8'd7); step();
    // R6 overwrite slot 0 fully; slot 5 now answers for the old key
    tag = "R6";
    wr(0, 20'h0ABCD, 20'h0, 8'd4, 0, 0, 1, 20'h0CAFE); look(20'h12345, 8'd5); step();
    look(20'h12345, 8'd5); step();
    look(20'h0ABCD, 8'd4); step();
    // R7 out-of-range writes
    tag = "R7";
    wr(16, 20'h0ABCD, 20'h0, 8'd4, 1, 1, 1, 20'h11111); look(20'h0ABCD, 8'd4); step();
    wr(31, 20'h0ABCD, 20'h0, 8'd4, 1, 1, 1, 20'h22222); step();
    look(20'h0ABCD, 8'd4); step();
    // R10 uncacheable region
    tag = "R10";
    lk_va = 32'hA000_0000; step();
    lk_va = 32'hBFFF_1234; step();
    lk_va = 32'h8000_0000; step();
    lk_va = 32'h2000_0000; step();
    lk_va = 32'hFFFF_FFFF; step();
    // R9 pointer walk and wrap
    tag = "R9";
    for (int k = 0; k < 20; k++) begin rp_adv = 1; step(); end
    step();
    // R8 flush wins over same-cycle write
    tag = "R8";
    flush = 1; rp_adv = 1; wr(2, 20'h0ABCD, 20'h0, 8'd4, 1, 1, 1, 20'h44444); step();
    look(20'h0ABCD, 8'd4); step();
    look(20'h12345, 8'd5); step();
    // R5 random mix against the model
    tag = "R5";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] < 3) wr(int'($urandom_range(0, 19)), {16'h0, 4'($urandom)},
                         {16'h0, 2'b0, 2'($urandom)}, 8'($urandom_range(0, 3)),
                         1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                         20'($urandom));
      if (r[9:3] == 0) flush = 1;
      rp_adv = r[10];
      look({16'h0, 4'($urandom)}, 8'($urandom_range(0, 3)));
      pr_vpn = {16'h0, 4'($urandom)}; pr_asid = 8'($urandom_range(0, 3));
      lk_va = $urandom;
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule